// File: doc/BRIEF.md
# Display-List Scanline Fetch Engine

This engine reads one 32-bit display-list entry per scanline and uses it to decide how that line is drawn. The entry gives a buffer start address, a rendering mode, a horizontal zoom, a selector field and an interrupt flag. A single frame may therefore mix graphics, text, blank and border lines. Consecutive entries may name the same buffer, so software can repeat a line or draw just ahead of the scan.

A timing generator drives three strobes. `frame_i` restarts the line count. `line_i` marks the start of horizontal blanking, and the engine then fetches the entry for the next line. `act_i` starts that line's active period and commits the entry. The engine then reads buffer words through a one-outstanding read port. It emits `H_ACT` pixel indices per non-blank line on a valid-qualified stream, which feeds a downstream line buffer and palette. Glyph rows come from an external font lookup that answers in the same cycle.

Top module: `dl_scan_engine`

## Requirements
- R1: After reset, `pix_valid_o`, `irq_o` and `rd_req_o` are 0, `cur_line_o` is 0 and `mode_o` reads blank (00).
- R2: After a `line_i` strobe, the first read request goes to word address `dl_base_i` + line index. A request holds its address until `rd_valid_i` accepts it.
- R3: In graphics mode (entry bits [31:30]=11), the depth is bits [26:24]+1, from 1 to 8, and bit 27 is ignored. Pixels are taken LSB-first from a continuous bit stream: word A holds stream bits 0..31, word A+1 holds bits 32..63, and so on. A is the entry address in bits [22:0]. Exactly `H_ACT` pixels are produced.
- R4: Entry bits [29:28] hold log2 of the zoom. Each source pixel (graphics) or glyph column (text) is repeated 1, 2, 4 or 8 times, and the line still ends after `H_ACT` outputs.
- R5: In text mode (10), each character takes one word: bits [7:0] hold the code, [15:8] the foreground and [23:16] the background. The font address is {code, entry bits [27:24]}. Glyph bit 7 is the leftmost column. A set bit gives the foreground and a clear bit gives the background.
- R6: In border mode (01), the line produces `H_ACT` pixels equal to `border_i` and issues no buffer read.
- R7: In blank mode (00), the line produces no valid pixel and issues no buffer read.
- R8: If the entry read has not completed in a cycle strictly before `act_i`, the line is a border line, its interrupt is suppressed and the late data is discarded.
- R9: `cur_line_o` takes the index of the committed line in the cycle after `act_i` and changes at no other time. `frame_i` makes the next line index 0.
- R10: `irq_o` is a one-cycle pulse in the cycle after `act_i` when the committed entry is on time and has bit 23 set.
- R11: Two lines whose entries are identical produce identical pixel sequences.
- R12: `mode_o` shows the mode in effect for the current line (border for a late line) from the cycle after `act_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame start; next line index becomes 0 |
| line_i | input | 1 | Horizontal blanking start; fetch next entry |
| act_i | input | 1 | Active period start; commit entry |
| dl_base_i | input | 23 | Word address of the entry for line 0 |
| border_i | input | 8 | Border colour index |
| rd_req_o | output | 1 | Read request, held until accepted |
| rd_addr_o | output | 23 | Read word address |
| rd_valid_i | input | 1 | Read data valid; completes the request |
| rd_data_i | input | 32 | Read data |
| font_addr_o | output | 12 | Font lookup address {code, row} |
| font_data_i | input | 8 | Glyph row bits, same cycle |
| pix_valid_o | output | 1 | Pixel index valid |
| pix_o | output | 8 | Pixel index |
| mode_o | output | 2 | Effective mode of the current line |
| cur_line_o | output | LINE_W | Index of the current line |
| irq_o | output | 1 | Display-list interrupt pulse |

## Verification
The hardest case to reach is an entry read that finishes too late. This includes a response that lands in the same cycle as `act_i`, which must count as late. The bench models memory with its own latency for entry addresses and stretches that latency past the gap between `line_i` and `act_i`. It stamps every response with a cycle count taken at the clock edge, so it decides on-time versus late without racing the strobe. It then expects a border line with no interrupt, and a normal line after it. The bench also reuses one entry on two lines and mixes depths, zooms and fetch latencies, so that the bit stream crosses word boundaries at different points.

// File: rtl/dl_scan_pkg.sv
package dl_scan_pkg;
  localparam int WORD_W = 32;
  localparam int AW     = 23;
  localparam int PIX_W  = 8;
  localparam int SEL_W  = 4;

  typedef enum logic [1:0] {
    M_BLANK  = 2'b00,
    M_BORDER = 2'b01,
    M_TEXT   = 2'b10,
    M_GFX    = 2'b11
  } mode_e;

  typedef struct packed {
    mode_e            mode;
    logic [1:0]       zoom;
    logic [SEL_W-1:0] sel;
    logic             irq;
    logic [AW-1:0]    addr;
  } entry_t;
endpackage

// File: rtl/dl_scan_req.sv
module dl_scan_req
  import dl_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              act_i,
  input  logic [AW-1:0]     ent_addr_i,
  input  logic              dat_want_i,
  input  logic [AW-1:0]     dat_addr_i,
  output logic              dat_issue_o,
  output logic              dat_valid_o,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output entry_t            ent_o,
  output logic              ent_ok_o
);
  logic pend_q, kind_q, drop_q;
  logic take, keep, issue_ent, issue_dat;

  always_comb begin
    take      = rd_req_o && rd_valid_i;
    // a response in the commit cycle or after it belongs to a finished line
    keep      = take && !drop_q && !act_i;
    issue_ent = !rd_req_o && pend_q && !act_i;
    issue_dat = !rd_req_o && !pend_q && dat_want_i && !act_i;
  end

  assign dat_issue_o = issue_dat;
  assign dat_valid_o = keep && !kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
      kind_q    <= 1'b0;
      drop_q    <= 1'b0;
      pend_q    <= 1'b0;
      ent_o     <= '0;
      ent_ok_o  <= 1'b0;
    end else begin
      if (take) begin
        rd_req_o <= 1'b0;
        drop_q   <= 1'b0;
      end else begin
        if (act_i && rd_req_o) drop_q <= 1'b1;
        if (issue_ent || issue_dat) begin
          rd_req_o  <= 1'b1;
          kind_q    <= issue_ent;
          rd_addr_o <= issue_ent ? ent_addr_i : dat_addr_i;
        end
      end
      if (act_i)          pend_q <= 1'b0;
      else if (line_i)    pend_q <= 1'b1;
      else if (issue_ent) pend_q <= 1'b0;
      if (keep && kind_q) begin
        ent_o    <= entry_t'(rd_data_i);
        ent_ok_o <= 1'b1;
      end else if (act_i || line_i) begin
        ent_ok_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dl_scan_render.sv
module dl_scan_render
  import dl_scan_pkg::*;
#(
  parameter int H_ACT = 640
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              ent_ok_i,
  input  mode_e             ent_mode_i,
  input  logic [1:0]        ent_zoom_i,
  input  logic [SEL_W-1:0]  ent_sel_i,
  input  logic [AW-1:0]     ent_addr_i,
  input  logic [PIX_W-1:0]  border_i,
  input  logic              dat_valid_i,
  input  logic [WORD_W-1:0] dat_i,
  input  logic              dat_issue_i,
  output logic              dat_want_o,
  output logic [AW-1:0]     dat_addr_o,
  output logic [PIX_W+SEL_W-1:0] font_addr_o,
  input  logic [PIX_W-1:0]  font_data_i,
  output logic              pix_valid_o,
  output logic [PIX_W-1:0]  pix_o,
  output mode_e             mode_o
);
  localparam int REM_W = $clog2(H_ACT + 1);
  localparam int BUF_W = 2 * WORD_W;
  localparam int CNT_W = $clog2(BUF_W + 1);

  mode_e            mode_q;
  logic [1:0]       zl_q;
  logic [SEL_W-1:0] sel_q;
  logic [REM_W-1:0] rem_q;
  logic [2:0]       rep_q, col_q;
  logic [BUF_W-1:0] buf_q, buf_sh, buf_d;
  logic [CNT_W-1:0] cnt_q, cnt_sh, cnt_d, need;
  logic [AW-1:0]    addr_q;

  logic [3:0]       depth;
  logic [2:0]       zmax;
  logic             is_data, last_rep, fire, consume;
  logic [PIX_W-1:0] gmask, gpix, tpix, pix_d;

  always_comb begin
    depth    = {1'b0, sel_q[2:0]} + 4'd1;
    is_data  = (mode_q == M_TEXT) || (mode_q == M_GFX);
    need     = (mode_q == M_TEXT) ? CNT_W'(WORD_W) : CNT_W'(depth);
    zmax     = 3'((4'd1 << zl_q) - 4'd1);
    last_rep = (rep_q == zmax);
    fire     = (rem_q != '0) && ((mode_q == M_BORDER) || (is_data && cnt_q >= need));
    consume  = fire && last_rep &&
               ((mode_q == M_GFX) || ((mode_q == M_TEXT) && (col_q == 3'd7)));
    gmask    = PIX_W'((9'd1 << depth) - 9'd1);
    gpix     = buf_q[PIX_W-1:0] & gmask;
    tpix     = font_data_i[3'd7 - col_q] ? buf_q[15:8] : buf_q[23:16];
    case (mode_q)
      M_BORDER: pix_d = border_i;
      M_TEXT:   pix_d = tpix;
      default:  pix_d = gpix;
    endcase
    buf_sh = consume ? (buf_q >> need) : buf_q;
    cnt_sh = consume ? (cnt_q - need) : cnt_q;
    buf_d  = buf_sh;
    cnt_d  = cnt_sh;
    if (dat_valid_i) begin
      buf_d = buf_sh | (BUF_W'(dat_i) << cnt_sh);
      cnt_d = cnt_sh + CNT_W'(WORD_W);
    end
  end

  assign dat_want_o  = is_data && (rem_q != '0) && (cnt_q <= CNT_W'(WORD_W));
  assign dat_addr_o  = addr_q;
  assign font_addr_o = {buf_q[7:0], sel_q};
  assign mode_o      = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= M_BLANK;
      zl_q        <= '0;
      sel_q       <= '0;
      rem_q       <= '0;
      rep_q       <= '0;
      col_q       <= '0;
      buf_q       <= '0;
      cnt_q       <= '0;
      addr_q      <= '0;
      pix_valid_o <= 1'b0;
      pix_o       <= '0;
    end else if (act_i) begin
      mode_q      <= ent_ok_i ? ent_mode_i : M_BORDER;
      zl_q        <= ent_zoom_i;
      sel_q       <= ent_sel_i;
      addr_q      <= ent_addr_i;
      rem_q       <= (ent_ok_i && ent_mode_i == M_BLANK) ? '0 : REM_W'(H_ACT);
      rep_q       <= '0;
      col_q       <= '0;
      buf_q       <= '0;
      cnt_q       <= '0;
      pix_valid_o <= 1'b0;
    end else begin
      buf_q <= buf_d;
      cnt_q <= cnt_d;
      if (dat_issue_i) addr_q <= addr_q + 1'b1;
      if (fire) begin
        rem_q <= rem_q - 1'b1;
        rep_q <= last_rep ? 3'd0 : rep_q + 3'd1;
        if (last_rep && mode_q == M_TEXT) col_q <= col_q + 3'd1;
      end
      pix_valid_o <= fire;
      pix_o       <= pix_d;
    end
  end
endmodule

// File: rtl/dl_scan_engine.sv
module dl_scan_engine
  import dl_scan_pkg::*;
#(
  parameter int H_ACT  = 640,
  parameter int LINE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              line_i,
  input  logic              act_i,
  input  logic [22:0]       dl_base_i,
  input  logic [7:0]        border_i,
  output logic              rd_req_o,
  output logic [22:0]       rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [31:0]       rd_data_i,
  output logic [11:0]       font_addr_o,
  input  logic [7:0]        font_data_i,
  output logic              pix_valid_o,
  output logic [7:0]        pix_o,
  output logic [1:0]        mode_o,
  output logic [LINE_W-1:0] cur_line_o,
  output logic              irq_o
);
  logic [LINE_W-1:0] nxt_q;
  logic [AW-1:0]     ent_addr, dat_addr;
  logic              dat_want, dat_issue, dat_valid, ent_ok;
  entry_t            ent;
  mode_e             mode;

  assign ent_addr = dl_base_i + AW'(nxt_q);
  assign mode_o   = mode;

  dl_scan_req u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_i      (line_i),
    .act_i       (act_i),
    .ent_addr_i  (ent_addr),
    .dat_want_i  (dat_want),
    .dat_addr_i  (dat_addr),
    .dat_issue_o (dat_issue),
    .dat_valid_o (dat_valid),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .rd_valid_i  (rd_valid_i),
    .rd_data_i   (rd_data_i),
    .ent_o       (ent),
    .ent_ok_o    (ent_ok)
  );

  dl_scan_render #(.H_ACT(H_ACT)) u_render (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act_i),
    .ent_ok_i    (ent_ok),
    .ent_mode_i  (ent.mode),
    .ent_zoom_i  (ent.zoom),
    .ent_sel_i   (ent.sel),
    .ent_addr_i  (ent.addr),
    .border_i    (border_i),
    .dat_valid_i (dat_valid),
    .dat_i       (rd_data_i),
    .dat_issue_i (dat_issue),
    .dat_want_o  (dat_want),
    .dat_addr_o  (dat_addr),
    .font_addr_o (font_addr_o),
    .font_data_i (font_data_i),
    .pix_valid_o (pix_valid_o),
    .pix_o       (pix_o),
    .mode_o      (mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_q      <= '0;
      cur_line_o <= '0;
      irq_o      <= 1'b0;
    end else begin
      if (frame_i)    nxt_q <= '0;
      else if (act_i) nxt_q <= nxt_q + 1'b1;
      if (act_i) cur_line_o <= nxt_q;
      irq_o <= act_i && ent_ok && ent.irq;
    end
  end
endmodule

// File: rtl/dl_scan_chk.sv
module dl_scan_chk #(
  parameter int LINE_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              act_i,
  input logic              irq_o,
  input logic              pix_valid_o,
  input logic [7:0]        pix_o,
  input logic [1:0]        mode_o,
  input logic [7:0]        border_i,
  input logic              rd_req_o,
  input logic              rd_valid_i,
  input logic [22:0]       rd_addr_o,
  input logic [LINE_W-1:0] cur_line_o
);
  // R10
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R10
  irq_after_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(act_i));

  // R7
  blank_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00) |-> !pix_valid_o);

  // R6
  border_colour_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && mode_o == 2'b01) |-> (pix_o == $past(border_i)));

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R9
  line_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> $stable(cur_line_o));
endmodule

bind dl_scan_engine dl_scan_chk #(.LINE_W(LINE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .act_i       (act_i),
  .irq_o       (irq_o),
  .pix_valid_o (pix_valid_o),
  .pix_o       (pix_o),
  .mode_o      (mode_o),
  .border_i    (border_i),
  .rd_req_o    (rd_req_o),
  .rd_valid_i  (rd_valid_i),
  .rd_addr_o   (rd_addr_o),
  .cur_line_o  (cur_line_o)
);

// File: tb/dl_scan_engine_bench.sv
`timescale 1ns/1ps
module dl_scan_engine_bench;
  localparam int H  = 16;
  localparam int LW = 11;
  localparam logic [22:0] DLB = 23'h400000;
  localparam logic [7:0]  BORDER = 8'hA7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic frame_i = 0, line_i = 0, act_i = 0;
  logic rd_req, rd_valid = 0;
  logic [22:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic [11:0] font_addr;
  logic [7:0]  font_data, pix;
  logic pix_valid, irq;
  logic [1:0] mode;
  logic [LW-1:0] cur_line;

  function automatic logic [31:0] hash_word(logic [22:0] a);
    return {a[15:0], a[22:7]} ^ (32'(a) * 32'h9E3779B1) ^ 32'h5A17C3E5;
  endfunction
  function automatic logic [7:0] font_fn(logic [11:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd197 + 16'd71;
    return t[7:0] ^ t[15:8];
  endfunction

  logic [31:0] dl_mem [0:63];
  function automatic logic [31:0] mem_rd(logic [22:0] a);
    if (a >= DLB && a < DLB + 23'd64) return dl_mem[6'(a - DLB)];
    return hash_word(a);
  endfunction

  assign font_data = font_fn(font_addr);

  dl_scan_engine #(.H_ACT(H), .LINE_W(LW)) u_dl_scan_engine (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame_i), .line_i(line_i), .act_i(act_i),
    .dl_base_i(DLB), .border_i(BORDER),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .font_addr_o(font_addr), .font_data_i(font_data),
    .pix_valid_o(pix_valid), .pix_o(pix), .mode_o(mode), .cur_line_o(cur_line), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, idx = 0;
  int ent_lat = 2, dat_lat = 2, rcnt = 0, ent_cyc = 0;
  bit ent_seen = 0, done = 0;
  logic [7:0] expq[$];
  string qtag = "R3";

  always @(posedge clk) cyc++;

  // memory model: fixed latency per request class
  initial begin
    forever begin
      @(negedge clk);
      if (rd_valid) rd_valid = 1'b0;
      else if (rd_req) begin
        rcnt++;
        if (rcnt >= ((rd_addr >= DLB) ? ent_lat : dat_lat)) begin
          rcnt = 0;
          rd_valid = 1'b1;
          rd_data = mem_rd(rd_addr);
          if (rd_addr >= DLB) begin ent_seen = 1; ent_cyc = cyc; end
        end
      end
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // pixel stream compared against the expected queue on every clock
  always @(negedge clk) begin
    if (rst_n && pix_valid) begin
      n_chk++;
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL %s pixel: actual=%0h expected=none", qtag, pix);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        if (pix !== e) begin
          n_bad++;
          $display("FAIL %s pixel: actual=%0h expected=%0h", qtag, pix, e);
        end
      end
    end
  end

  function automatic logic [31:0] mk(logic [1:0] m, logic [1:0] zl, logic [3:0] sel,
                                     logic ir, logic [22:0] a);
    return {m, zl, sel, ir, a};
  endfunction

  task automatic push_line(logic [31:0] e, logic [1:0] m);
    int z;
    logic [22:0] a;
    z = 1 << e[29:28];
    a = e[22:0];
    if (m == 2'b00) return;
    for (int p = 0; p < H; p++) begin
      int s;
      logic [7:0] v;
      s = p / z;
      v = '0;
      if (m == 2'b01) v = BORDER;
      else if (m == 2'b11) begin
        int d;
        d = int'(e[26:24]) + 1;
        for (int b = 0; b < d; b++) begin
          int bi;
          logic [31:0] w;
          bi = s * d + b;
          w = mem_rd(a + 23'(bi / 32));
          v[b] = w[bi % 32];
        end
      end else begin
        logic [31:0] w;
        logic [7:0] g;
        w = mem_rd(a + 23'(s / 8));
        g = font_fn({w[7:0], e[27:24]});
        v = g[7 - (s % 8)] ? w[15:8] : w[23:16];
      end
      expq.push_back(v);
    end
  endtask

  task automatic run_line(logic [31:0] e, int elat, int dlat, string tag);
    bit seen, ok;
    int ndata;
    logic [1:0] em;
    seen = 0; ndata = 0;
    dl_mem[idx] = e;
    ent_lat = elat; dat_lat = dlat; ent_seen = 0;
    @(negedge clk); line_i = 1;
    @(negedge clk); line_i = 0;
    repeat (8) begin
      @(negedge clk);
      if (!seen && rd_req) begin
        seen = 1;
        chk("R2", "entry address", rd_addr, DLB + 23'(idx));
      end
    end
    @(negedge clk);
    act_i = 1;
    ok = ent_seen && (ent_cyc < cyc);
    em = ok ? e[31:30] : 2'b01;
    qtag = ok ? tag : "R8";
    push_line(e, em);
    @(negedge clk);
    act_i = 0;
    chk("R9", "current line", cur_line, idx);
    chk("R10", "interrupt pulse", irq, ok && e[23]);
    chk("R12", "line mode", mode, em);
    if (!ok) chk("R8", "late entry seen as late", 1, (elat > 8) ? 1 : 0);
    @(negedge clk);
    chk("R10", "interrupt one cycle", irq, 0);
    repeat (110) begin
      @(negedge clk);
      if (rd_req && rd_addr < DLB) ndata++;
    end
    chk(tag, "pixels outstanding at line end", expq.size(), 0);
    if (em == 2'b00) chk("R7", "blank line data reads", ndata, 0);
    if (em == 2'b01) chk("R6", "border line data reads", ndata, 0);
    idx++;
  endtask

  task automatic new_frame();
    @(negedge clk); frame_i = 1;
    @(negedge clk); frame_i = 0;
    idx = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) dl_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset pix_valid", pix_valid, 0);
    chk("R1", "reset irq", irq, 0);
    chk("R1", "reset rd_req", rd_req, 0);
    chk("R1", "reset cur_line", cur_line, 0);
    chk("R1", "reset mode", mode, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    new_frame();
    run_line(mk(2'b11, 2'd0, 4'd7, 1'b1, 23'h000100), 2, 2, "R3");  // 8 bpp, irq
    run_line(mk(2'b11, 2'd0, 4'd0, 1'b0, 23'h000200), 1, 3, "R3");  // 1 bpp
    run_line(mk(2'b11, 2'd1, 4'd2, 1'b0, 23'h000240), 3, 1, "R4");  // 3 bpp x2
    run_line(mk(2'b10, 2'd0, 4'd5, 1'b0, 23'h000300), 2, 2, "R5");  // text row 5
    run_line(mk(2'b10, 2'd1, 4'd9, 1'b1, 23'h000310), 1, 3, "R5");  // text x2, irq
    run_line(mk(2'b00, 2'd0, 4'd0, 1'b1, 23'h000400), 2, 2, "R7");  // blank, irq
    run_line(mk(2'b01, 2'd2, 4'd3, 1'b0, 23'h000410), 2, 2, "R6");  // border
    run_line(mk(2'b11, 2'd3, 4'd3, 1'b0, 23'h000420), 2, 2, "R4");  // 4 bpp x8
    run_line(mk(2'b11, 2'd0, 4'd4, 1'b0, 23'h000500), 2, 1, "R11"); // 5 bpp
    run_line(mk(2'b11, 2'd0, 4'd4, 1'b0, 23'h000500), 3, 3, "R11"); // same buffer
    run_line(mk(2'b11, 2'd0, 4'd7, 1'b1, 23'h000600), 30, 2, "R8"); // late entry
    run_line(mk(2'b11, 2'd2, 4'd15, 1'b0, 23'h000700), 1, 2, "R3"); // bit 27 ignored
    new_frame();
    run_line(mk(2'b11, 2'd0, 4'd6, 1'b1, 23'h000800), 2, 3, "R9");  // 7 bpp, line 0
    run_line(mk(2'b10, 2'd2, 4'd1, 1'b0, 23'h000900), 2, 2, "R5");  // text x4
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule